// File: doc/BRIEF.md
# MPDU Header HT-Control and Length Adjuster

This block sits in the transmit path ahead of the header builder. For each MPDU descriptor it produces three results: the final 16-bit frame-control word, a flag that says whether an HT/HE control field is present, and the MPDU length after corrections. Setting the Order bit of frame control (bit 15) normally means the frame carries 4 placeholder bytes for the control field, and a later stage fills them in. A notify frame may be sent at a legacy rate that cannot carry that field. When software sets the no-HTC override flag on such a frame, the block drops the field. It clears the Order bit and the present flag, and it removes the 4 bytes from the length.

Firmware can also replace the per-queue header overhead. When the override is enabled, the block subtracts the queue's header length and adds a 9-bit override value. The header-length override is applied first and the 4-byte removal second. Lengths are 14-bit unsigned values. An underflow raises an error flag and forces the length to zero. A result above the 14-bit range saturates.

Descriptors enter on a valid/ready handshake and leave from a single output register stage, which also has a valid/ready handshake.

Top module: `hdr_htc_len_adj`

## Requirements
- R1: After reset, `out_valid`, `out_fc`, `out_htc`, `out_len` and `out_err` are all 0. `in_ready` is high whenever `out_valid` is 0 or `out_ready` is 1. A descriptor accepted at a clock edge (`in_valid` and `in_ready` both high) appears on the outputs with `out_valid` = 1 after that same edge.
- R2: While `out_valid` is 1 and `out_ready` is 0, every output holds its value and no new descriptor is accepted.
- R3: Suppression is active when `in_no_htc` is 1 and `in_notify` is nonzero. The notify codes are 0 = none, 1 = hard, 2 = soft and 3 = semi-hard. Under suppression, `out_fc[15]` (the Order bit) is 0 and `out_htc` is 0. Otherwise `out_fc[15]` equals `in_fc[15]` and `out_htc` equals `in_htc_req`.
- R4: `out_fc[14:0]` always equals `in_fc[14:0]`. These bits include the protocol version [1:0], the type [3:2] and the subtype [7:4].
- R5: With `in_ovr_en` = 0 and no suppression, `out_len` equals `in_len`. With `in_ovr_en` = 1, the length becomes `in_len - in_qhdr_len + in_ovr_val`.
- R6: The override is applied before the 4-byte removal. Under suppression with no underflow, `out_len` = (length after R5) - 4.
- R7: If `in_len < in_qhdr_len` with the override enabled, or if the length after the override is below 4 under suppression, then `out_err` = 1 and `out_len` = 0. Otherwise `out_err` = 0.
- R8: If the override result exceeds 16383, it saturates to 16383 before the removal step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Block can accept a descriptor |
| in_fc | input | 16 | Frame-control word |
| in_htc_req | input | 1 | HT/HE control field requested |
| in_no_htc | input | 1 | Drop the control field on notify frames |
| in_notify | input | 2 | Notify type: 0 none, 1 hard, 2 soft, 3 semi-hard |
| in_len | input | 14 | MPDU length in bytes |
| in_qhdr_len | input | 14 | Queue header length |
| in_ovr_en | input | 1 | Header-length override enable |
| in_ovr_val | input | 9 | Header-length override value |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_fc | output | 16 | Final frame-control word |
| out_htc | output | 1 | HT/HE control field present |
| out_len | output | 14 | Adjusted MPDU length |
| out_err | output | 1 | Length underflow detected |

## Verification
The hardest case to reach is the one where the order of the two corrections decides the result. The override must lift a short length above 4 before the removal step, so reversing the order would turn a valid length into an underflow. A second hard case is saturation, where the override pushes a near-maximum length past the 14-bit range. Directed descriptors are placed on both edges of each corner: an input length of 2 with an override value of 10, lengths of 3 and 4 under suppression, the largest length plus the largest override value, and a header length one above the input length. Random traffic then runs with `out_ready` randomly held low, so descriptors wait in the output register, and a behavioural queue model compares every output on every clock.

// File: rtl/hdr_htc_len_adj.sv
module hdr_htc_len_adj #(
  parameter int LEN_W     = 14,
  parameter int OVR_W     = 9,
  parameter int FC_W      = 16,
  parameter int NTF_W     = 2,
  parameter int HTC_BYTES = 4,
  parameter int ORDER_BIT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FC_W-1:0]  in_fc,
  input  logic             in_htc_req,
  input  logic             in_no_htc,
  input  logic [NTF_W-1:0] in_notify,
  input  logic [LEN_W-1:0] in_len,
  input  logic [LEN_W-1:0] in_qhdr_len,
  input  logic             in_ovr_en,
  input  logic [OVR_W-1:0] in_ovr_val,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [FC_W-1:0]  out_fc,
  output logic             out_htc,
  output logic [LEN_W-1:0] out_len,
  output logic             out_err
);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
  localparam logic [LEN_W:0]   HTC_DEC = (LEN_W+1)'(HTC_BYTES);

  logic             supp, fire;
  logic [LEN_W:0]   diff_q, sum_o, diff_h;
  logic             uf_ovr, uf_htc, err_n;
  logic [LEN_W-1:0] len_a, len_n;
  logic [FC_W-1:0]  fc_n;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign supp     = in_no_htc && (in_notify != '0);

  assign diff_q = {1'b0, in_len} - {1'b0, in_qhdr_len};
  assign uf_ovr = in_ovr_en && diff_q[LEN_W];
  assign sum_o  = diff_q + (LEN_W+1)'(in_ovr_val);

  always_comb begin
    if (!in_ovr_en)        len_a = in_len;
    else if (uf_ovr)       len_a = '0;
    else if (sum_o[LEN_W]) len_a = LEN_MAX;
    else                   len_a = sum_o[LEN_W-1:0];
  end

  assign diff_h = {1'b0, len_a} - HTC_DEC;
  assign uf_htc = supp && diff_h[LEN_W];
  assign err_n  = uf_ovr || uf_htc;

  always_comb begin
    if (err_n)     len_n = '0;
    else if (supp) len_n = diff_h[LEN_W-1:0];
    else           len_n = len_a;
  end

  assign fc_n = in_fc & ~(FC_W'(supp) << ORDER_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fc    <= '0;
      out_htc   <= 1'b0;
      out_len   <= '0;
      out_err   <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_fc    <= fc_n;
      out_htc   <= in_htc_req && !supp;
      out_len   <= len_n;
      out_err   <= err_n;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_fc) && $stable(out_len)
                                   && $stable(out_htc) && $stable(out_err)));

  assert_suppress_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_no_htc && in_notify != '0) |=> (!out_htc && !out_fc[ORDER_BIT]));

  assert_fc_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (out_fc[ORDER_BIT-1:0] == $past(in_fc[ORDER_BIT-1:0])));

  assert_plain_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_ovr_en && !(in_no_htc && in_notify != '0)) |=> (out_len == $past(in_len) && !out_err));

  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_len == '0));
endmodule

// File: tb/test_hdr_htc_len_adj.sv
module test_hdr_htc_len_adj;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_htc_req = 0, in_no_htc = 0, in_ovr_en = 0;
  logic [15:0] in_fc = 0;
  logic [1:0]  in_notify = 0;
  logic [13:0] in_len = 0, in_qhdr_len = 0;
  logic [8:0]  in_ovr_val = 0;
  logic out_valid, out_ready = 0, out_htc, out_err;
  logic [15:0] out_fc;
  logic [13:0] out_len;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] q_fc[$], q_len[$];
  bit q_htc[$], q_err[$];

  always #10 clk = ~clk;

  hdr_htc_len_adj i_hdr_htc_len_adj (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fc(in_fc), .in_htc_req(in_htc_req), .in_no_htc(in_no_htc),
    .in_notify(in_notify), .in_len(in_len), .in_qhdr_len(in_qhdr_len),
    .in_ovr_en(in_ovr_en), .in_ovr_val(in_ovr_val), .out_valid(out_valid),
    .out_ready(out_ready), .out_fc(out_fc), .out_htc(out_htc),
    .out_len(out_len), .out_err(out_err));

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_model();
    bit supp = in_no_htc && (in_notify != 0);
    int l = in_len;
    bit e = 0;
    if (in_ovr_en) begin
      if (in_len < in_qhdr_len) e = 1;
      else begin
        l = in_len - in_qhdr_len + in_ovr_val;
        if (l > 16383) l = 16383;
      end
    end
    if (supp && !e) begin
      if (l < 4) e = 1; else l = l - 4;
    end
    if (e) l = 0;
    q_fc.push_back(supp ? (in_fc & 16'h7fff) : in_fc);
    q_htc.push_back(in_htc_req && !supp);
    q_len.push_back(l);
    q_err.push_back(e);
  endtask

  task automatic compare();
    chk("R1 R2 out_valid", out_valid, q_fc.size() != 0);
    chk("R1 in_ready", in_ready, !out_valid || out_ready);
    if (out_valid && q_fc.size() != 0) begin
      chk("R4 fc low bits", out_fc[14:0], q_fc[0][14:0]);
      chk("R3 order bit", out_fc[15], q_fc[0][15]);
      chk("R3 htc flag", out_htc, q_htc[0]);
      chk("R5 R6 R8 length", out_len, q_len[0]);
      chk("R7 error flag", out_err, q_err[0]);
    end
  endtask

  task automatic step(input bit v, input bit rdy, input logic [15:0] fc, input bit req,
                      input bit noh, input logic [1:0] ntf, input logic [13:0] len,
                      input logic [13:0] qh, input bit oe, input logic [8:0] ov);
    @(negedge clk);
    compare();
    in_valid = v; out_ready = rdy; in_fc = fc; in_htc_req = req; in_no_htc = noh;
    in_notify = ntf; in_len = len; in_qhdr_len = qh; in_ovr_en = oe; in_ovr_val = ov;
    #1;
    if (out_valid && out_ready) begin
      void'(q_fc.pop_front()); void'(q_htc.pop_front());
      void'(q_len.pop_front()); void'(q_err.pop_front());
    end
    if (in_valid && in_ready) push_model();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset out_fc", out_fc, 0);
    chk("R1 reset out_len", out_len, 0);
    chk("R1 reset out_err", out_err, 0);
    rst_n = 1;
    // R3: notify 0 with flag set keeps HTC; codes 1..3 suppress
    step(1, 1, 16'h8088, 1, 1, 0, 100, 0, 0, 0);
    step(1, 1, 16'h80c8, 1, 1, 1, 100, 0, 0, 0);
    step(1, 1, 16'hffff, 1, 1, 2, 100, 0, 0, 0);
    step(1, 1, 16'h8001, 1, 1, 3, 100, 0, 0, 0);
    step(1, 1, 16'h8001, 1, 0, 3, 100, 0, 0, 0);
    // R5 override, R6 order of corrections
    step(1, 1, 16'h0088, 0, 0, 0, 200, 30, 1, 24);
    step(1, 1, 16'h8088, 1, 1, 1, 2, 0, 1, 10);
    // R7 underflows at both steps and at the boundary
    step(1, 1, 16'h0088, 0, 0, 0, 19, 20, 1, 5);
    step(1, 1, 16'h0088, 0, 0, 0, 20, 20, 1, 0);
    step(1, 1, 16'h8088, 1, 1, 2, 3, 0, 0, 0);
    step(1, 1, 16'h8088, 1, 1, 2, 4, 0, 0, 0);
    // R8 saturation
    step(1, 1, 16'h0088, 0, 0, 0, 16383, 0, 1, 511);
    step(1, 1, 16'h8088, 1, 1, 1, 16380, 1, 1, 511);
    // R2 hold while downstream stalls
    step(1, 0, 16'h1234, 1, 0, 0, 77, 0, 0, 0);
    step(1, 0, 16'h5678, 0, 1, 1, 88, 0, 0, 0);
    step(1, 0, 16'h9abc, 1, 1, 2, 99, 0, 0, 0);
    step(0, 1, 16'h0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0, 16'($urandom),
           1'($urandom), 1'($urandom), 2'($urandom),
           ($urandom_range(0, 3) == 0) ? 14'($urandom_range(0, 8)) : 14'($urandom),
           ($urandom_range(0, 1) == 0) ? 14'($urandom_range(0, 64)) : 14'($urandom),
           1'($urandom), 9'($urandom));
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule